// File: doc/BRIEF.md
# Add/Logic ALU with Condition Flags

This block is the combinational integer datapath of a 64-bit load/store core. It covers addition and subtraction, each with or without the incoming carry. It also covers the three bitwise operations AND, OR and XOR, plus a variant of each that complements the second operand first. A width select picks between full 64-bit operation and 32-bit operation on the low halves of the operands.

The caller supplies the current four-bit condition state. When the flag-update enable is set, the block returns a new condition state. When the enable is clear, the state passes through unchanged. Register reads, decode, shifting and division are done elsewhere.

Because the block holds no state, a result appears in the same cycle its inputs are applied.

Top module: `alu_flags_core`

## Requirements
- R1: Opcode 0 returns a+b. Opcode 1 returns a+b+C, where C is the incoming carry flag.
- R2: Opcode 2 returns a-b. Opcode 3 returns a-b-(1-C), so a set carry means no borrow.
- R3: The logic opcodes are 4 (a AND b), 5 (a AND NOT b), 6 (a OR b), 7 (a OR NOT b), 8 (a XOR b) and 9 (a XOR NOT b).
- R4: When wide_i is 0, only the low 32 bits of both operands are used and the carry-in is added at 32-bit width. Result bits 63:32 are then zero.
- R5: Flag vectors are ordered {N,Z,C,V}, with N at bit 3 and V at bit 0. For a flag-setting operation, N is the top bit of the selected width and Z is set when the result in the selected width is zero.
- R6: For opcodes 0 and 1, C is the unsigned carry out of the selected width. V is set when both operands have equal signs and the result sign differs from them.
- R7: For opcodes 2 and 3, C is set when no unsigned borrow occurs. V is set when the operand signs differ and the result sign differs from the first operand.
- R8: For flag-setting logic opcodes, C and V are forced to 0.
- R9: When set_flags_i is 0, nzcv_o equals nzcv_i for every opcode.
- R10: Opcodes 10 to 15 return a zero result and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| set_flags_i | input | 1 | Enables the flag update |
| nzcv_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 64 | Operation result |
| nzcv_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block with the default XLEN of 64, so the half width is 32. Both widths are therefore exercised on one instance. Operands are drawn randomly but biased toward zero, all-ones and the two sign-boundary patterns, which reaches carry out, signed overflow and borrow at both the bit-31 and bit-63 boundaries. The 32-bit vectors carry junk in their upper halves, which exposes any leak of the upper operand bits into the result or the flags.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_AND = 4'd4, OP_BIC = 4'd5, OP_ORR = 4'd6, OP_ORN = 4'd7,
    OP_EOR = 4'd8, OP_EON = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {LK_AND = 2'd0, LK_OR = 2'd1, LK_XOR = 2'd2} logic_kind_e;

  typedef enum logic [1:0] {CL_NONE = 2'd0, CL_ADD = 2'd1, CL_SUB = 2'd2, CL_LOGIC = 2'd3} op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_flags_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] b_i,
  input  logic [3:0]      op_i,
  input  logic            carry_i,
  output logic [XLEN-1:0] b_eff_o,
  output logic            cin_o,
  output op_class_e       cls_o,
  output logic_kind_e     kind_o
);
  logic invert;

  always_comb begin
    invert = 1'b0;
    cin_o  = 1'b0;
    cls_o  = CL_NONE;
    kind_o = LK_AND;
    unique case (op_i)
      OP_ADD: cls_o = CL_ADD;
      OP_ADC: begin cls_o = CL_ADD; cin_o = carry_i; end
      // subtract as a + ~b + 1; with carry, the carry itself is the +1
      OP_SUB: begin cls_o = CL_SUB; invert = 1'b1; cin_o = 1'b1; end
      OP_SBC: begin cls_o = CL_SUB; invert = 1'b1; cin_o = carry_i; end
      OP_AND: begin cls_o = CL_LOGIC; kind_o = LK_AND; end
      OP_BIC: begin cls_o = CL_LOGIC; kind_o = LK_AND; invert = 1'b1; end
      OP_ORR: begin cls_o = CL_LOGIC; kind_o = LK_OR; end
      OP_ORN: begin cls_o = CL_LOGIC; kind_o = LK_OR; invert = 1'b1; end
      OP_EOR: begin cls_o = CL_LOGIC; kind_o = LK_XOR; end
      OP_EON: begin cls_o = CL_LOGIC; kind_o = LK_XOR; invert = 1'b1; end
      default: ;
    endcase
    b_eff_o = invert ? ~b_i : b_i;
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            cin_i,
  input  logic            wide_i,
  output logic [XLEN-1:0] sum_o,
  output logic            cout_o,
  output logic            ovf_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN:0] full_sum;
  logic [HALF:0] half_sum;
  logic          sa, sb, sr;

  always_comb begin
    full_sum = {1'b0, a_i} + {1'b0, b_i} + {{XLEN{1'b0}}, cin_i};
    half_sum = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
    if (wide_i) begin
      sum_o  = full_sum[XLEN-1:0];
      cout_o = full_sum[XLEN];
      sa     = a_i[XLEN-1];
      sb     = b_i[XLEN-1];
      sr     = full_sum[XLEN-1];
    end else begin
      sum_o  = {{(XLEN-HALF){1'b0}}, half_sum[HALF-1:0]};
      cout_o = half_sum[HALF];
      sa     = a_i[HALF-1];
      sb     = b_i[HALF-1];
      sr     = half_sum[HALF-1];
    end
    // b is already complemented for subtract, so one rule covers both
    ovf_o = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_flags_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic_kind_e     kind_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (kind_i)
      LK_AND:  y_o = a_i & b_i;
      LK_OR:   y_o = a_i | b_i;
      LK_XOR:  y_o = a_i ^ b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flags_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] result_i,
  input  logic            wide_i,
  input  logic            cout_i,
  input  logic            ovf_i,
  input  op_class_e       cls_i,
  input  logic            set_i,
  input  nzcv_t           cur_i,
  output nzcv_t           nxt_o
);
  localparam int HALF = XLEN / 2;

  logic n_bit, z_bit;

  always_comb begin
    n_bit = wide_i ? result_i[XLEN-1] : result_i[HALF-1];
    z_bit = wide_i ? (result_i == '0) : (result_i[HALF-1:0] == '0);
    nxt_o = cur_i;
    if (set_i) begin
      unique case (cls_i)
        CL_ADD, CL_SUB: nxt_o = '{n: n_bit, z: z_bit, c: cout_i, v: ovf_i};
        CL_LOGIC:       nxt_o = '{n: n_bit, z: z_bit, c: 1'b0, v: 1'b0};
        default:        nxt_o = cur_i;
      endcase
    end
  end

  always_comb begin
    // R8: logic ops never report carry or overflow
    a_r8_logic_cv_clear: assert (!(set_i && cls_i == CL_LOGIC) || (!nxt_o.c && !nxt_o.v))
      else $error("logic op produced C or V");
  end
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flags_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [3:0]      op_i,
  input  logic            wide_i,
  input  logic            set_flags_i,
  input  logic [3:0]      nzcv_i,
  output logic [XLEN-1:0] result_o,
  output logic [3:0]      nzcv_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] b_eff, sum, logic_y;
  logic            cin, cout, ovf;
  op_class_e       cls;
  logic_kind_e     kind;
  nzcv_t           cur, nxt;

  assign cur = nzcv_t'(nzcv_i);

  alu_operand_prep #(.XLEN(XLEN)) u_prep (
    .b_i(b_i), .op_i(op_i), .carry_i(cur.c),
    .b_eff_o(b_eff), .cin_o(cin), .cls_o(cls), .kind_o(kind)
  );

  alu_adder #(.XLEN(XLEN)) u_add (
    .a_i(a_i), .b_i(b_eff), .cin_i(cin), .wide_i(wide_i),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  alu_logic_unit #(.XLEN(XLEN)) u_logic (
    .a_i(a_i), .b_i(b_eff), .kind_i(kind), .y_o(logic_y)
  );

  always_comb begin
    unique case (cls)
      CL_ADD, CL_SUB: result_o = sum;
      CL_LOGIC:       result_o = wide_i ? logic_y : {{(XLEN-HALF){1'b0}}, logic_y[HALF-1:0]};
      default:        result_o = '0;
    endcase
  end

  alu_flag_gen #(.XLEN(XLEN)) u_flags (
    .result_i(result_o), .wide_i(wide_i), .cout_i(cout), .ovf_i(ovf),
    .cls_i(cls), .set_i(set_flags_i), .cur_i(cur), .nxt_o(nxt)
  );

  assign nzcv_o = nxt;

  always_comb begin
    a_r4_upper_zero: assert (wide_i || result_o[XLEN-1:HALF] == '0)
      else $error("upper half nonzero in narrow mode");
    a_r9_flags_hold: assert (set_flags_i || nzcv_o == nzcv_i)
      else $error("flags changed without enable");
    a_r5_zero_flag: assert (!(set_flags_i && cls != CL_NONE) || nzcv_o[2] == (result_o == '0))
      else $error("Z disagrees with result");
    a_r6_add_carry: assert (!(set_flags_i && wide_i && op_i == OP_ADD) || nzcv_o[1] == (result_o < a_i))
      else $error("add carry disagrees with wraparound");
    a_r10_undef_zero: assert (op_i < 4'd10 || result_o == '0)
      else $error("undefined opcode gave nonzero result");
  end
endmodule

// File: tb/alu_flags_core_tb_top.sv
module alu_flags_core_tb_top;
  logic        clk = 1'b0;
  logic [63:0] a, b, res;
  logic [3:0]  op, fin, fout;
  logic        wide, sf;
  int          n_checks = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  alu_flags_core dut_i (
    .a_i(a), .b_i(b), .op_i(op), .wide_i(wide), .set_flags_i(sf),
    .nzcv_i(fin), .result_o(res), .nzcv_o(fout)
  );

  function automatic logic ovf_of(input logic signed [127:0] s, input int w);
    logic signed [127:0] lim;
    lim = 128'sd1 <<< (w - 1);
    return (s >= lim) || (s < -lim);
  endfunction

  task automatic ref_model(input logic [3:0] o, input logic [63:0] x, y, input logic wd, s_en,
                           input logic [3:0] f, output logic [63:0] r, output logic [3:0] fo);
    int w;
    logic [127:0] mask, ux, uy, u;
    logic signed [127:0] sx, sy, s;
    logic c, v, valid, k;
    w = wd ? 64 : 32;
    mask = (128'd1 << w) - 1;
    ux = {64'd0, x} & mask;
    uy = {64'd0, y} & mask;
    sx = wd ? {{64{x[63]}}, x} : {{96{x[31]}}, x[31:0]};
    sy = wd ? {{64{y[63]}}, y} : {{96{y[31]}}, y[31:0]};
    c = 1'b0; v = 1'b0; valid = 1'b1; u = '0;
    case (o)
      4'd0, 4'd1: begin
        k = (o == 4'd1) ? f[1] : 1'b0;
        u = ux + uy + 128'(k);
        c = (u >> w) != 0;
        s = sx + sy + 128'(k);
        v = ovf_of(s, w);
      end
      4'd2, 4'd3: begin
        k = (o == 4'd3) ? ~f[1] : 1'b0;
        u = ux - uy - 128'(k);
        c = ux >= uy + 128'(k);
        s = sx - sy - 128'(k);
        v = ovf_of(s, w);
      end
      4'd4: u = ux & uy;
      4'd5: u = ux & ~uy;
      4'd6: u = ux | uy;
      4'd7: u = ux | ~uy;
      4'd8: u = ux ^ uy;
      4'd9: u = ux ^ ~uy;
      default: valid = 1'b0;
    endcase
    u = u & mask;
    r = u[63:0];
    fo = (s_en && valid) ? {r[w-1], r == 64'd0, c, v} : f;
  endtask

  task automatic check(input string tag, input logic [63:0] act, exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d wide=%0b sf=%0b act=%h exp=%h", tag, op, wide, sf, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [63:0] x, y, input logic wd, s_en, input logic [3:0] f);
    logic [63:0] er;
    logic [3:0]  ef;
    string rt, ft;
    @(posedge clk);
    op = o; a = x; b = y; wide = wd; sf = s_en; fin = f;
    ref_model(o, x, y, wd, s_en, f, er, ef);
    @(negedge clk);
    if (o <= 4'd1) begin rt = "R1"; ft = "R6"; end
    else if (o <= 4'd3) begin rt = "R2"; ft = "R7"; end
    else if (o <= 4'd9) begin rt = "R3"; ft = "R8"; end
    else begin rt = "R10"; ft = "R10"; end
    if (!s_en) ft = "R9";
    check(rt, res, er);
    if (!wd) check("R4", {32'd0, res[63:32]}, 64'd0);
    check("R5", {62'd0, fout[3:2]}, {62'd0, ef[3:2]});
    check(ft, {62'd0, fout[1:0]}, {62'd0, ef[1:0]});
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7fff_ffff_ffff_ffff;
      4: return {$urandom, 32'h8000_0000};
      5: return {$urandom, 32'h7fff_ffff};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    a = '0; b = '0; op = 4'd15; wide = 1'b1; sf = 1'b0; fin = 4'b1010;
    // reset-state style check: idle undefined opcode passes flags, zero result
    #1;
    check("R10", res, 64'd0);
    check("R9", {60'd0, fout}, {60'd0, 4'b1010});
    // directed corners
    run(4'd0, '1, 64'd1, 1'b1, 1'b1, 4'b0000);                       // R6 carry, zero
    run(4'd0, 64'h7fff_ffff_ffff_ffff, 64'd1, 1'b1, 1'b1, 4'b0000);  // R6 overflow
    run(4'd0, 64'hdead_beef_ffff_ffff, 64'h1234_0000_0000_0001, 1'b0, 1'b1, 4'b0000); // R4 carry at 32
    run(4'd1, 64'h0, 64'h0, 1'b1, 1'b1, 4'b0010);                    // R1 carry-in
    run(4'd2, 64'h8000_0000_0000_0000, 64'd1, 1'b1, 1'b1, 4'b0000);  // R7 overflow
    run(4'd2, 64'd1, 64'd2, 1'b1, 1'b1, 4'b0010);                    // R7 borrow
    run(4'd3, 64'd5, 64'd5, 1'b1, 1'b1, 4'b0010);                    // R2 no borrow
    run(4'd3, 64'd5, 64'd5, 1'b0, 1'b1, 4'b0000);                    // R2 borrow
    run(4'd5, '1, '1, 1'b1, 1'b1, 4'b0011);                          // R8 clear C,V
    run(4'd9, 64'hffff_0000_0000_0000, 64'h0, 1'b0, 1'b1, 4'b0011);  // R4 narrow logic
    run(4'd0, '1, 64'd1, 1'b1, 1'b0, 4'b0101);                       // R9 no update
    run(4'd12, '1, '1, 1'b1, 1'b1, 4'b1111);                         // R10
    for (int i = 0; i < 3000; i++)
      run(4'($urandom % 16), pick(), pick(), 1'($urandom), 1'($urandom % 4 != 0), 4'($urandom));
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule